// File: doc/BRIEF.md
# Interrupt Request Control Register Bank

This block owns eight interrupt request lines, two for each of four expansion sites, and gives each line its own byte-wide control register on a simple synchronous register bus. Software sets, for each line, whether the raw request is active high or active low and whether it is latched on an edge or passed through as a level. Software also gives each line an enable and a three-bit priority level. The block reports whether each line is pending. In edge mode, software clears a pending line by writing a one to a self-clearing command bit.

Raw requests arrive asynchronously and pass through a synchronizer before detection. For each line, the block produces a registered interrupt flag and its level. It also produces a registered summary that gives the highest level among all lines currently interrupting, so an interrupt controller further up can compare one priority number rather than eight.

Top module: `irq_ctrl_bank`

## Requirements
- R1: The control registers sit at byte addresses BASE_ADDR+0 to BASE_ADDR+7 (0x10..0x17 by default), and channel index equals the offset (channel 0 at 0x10, channel 7 at 0x17). Read data is registered and appears one cycle after the address is presented. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: Register fields are: bit 7 polarity (1 active high / rising, 0 active low / falling), bit 6 mode (1 edge-latched, 0 level), bit 5 pending status, bit 4 enable, bit 3 clear command, and bits 2:0 level. Polarity, mode, enable and level read back as written.
- R3: The pending bit is read-only. The value written to bit 5 has no effect.
- R4: The clear command bit always reads as 0.
- R5: In edge mode, an active edge on the synchronized request sets pending. Pending then stays set after the request returns to idle.
- R6: In edge mode, writing a 1 to bit 3 clears pending. If a new active edge arrives in the same cycle, the edge wins. In level mode, bit 3 has no effect.
- R7: In level mode, pending follows the synchronized request after polarity is applied.
- R8: With polarity 0, a low request is active and a falling edge is the active edge. With polarity 1, a high request is active and a rising edge is the active edge.
- R9: ch_irq[i] is 1 only when pending, enable and a nonzero level are all present. ch_lvl for that channel then carries its level, and otherwise carries 0. A level of 0 never interrupts. After a change at irq_raw, ch_irq responds on the fourth rising edge.
- R10: top_lvl equals the largest ch_lvl value among interrupting channels, or 0 when none is interrupting. It is valid in the same cycle as ch_irq.
- R11: Synchronous reset clears every register bit and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_raw | input | NUM_CH | Asynchronous raw request lines |
| ch_irq | output | NUM_CH | Per-channel active interrupt |
| ch_lvl | output | 3*NUM_CH | Per-channel active level, channel i at bits 3i+2:3i |
| top_lvl | output | 3 | Highest active level |

## Verification
Each result has a fixed latency. Read data is due one cycle after the address. A configuration write reaches ch_irq two cycles after the strobe, or three cycles if the write also changes a level-mode pending bit. A change at irq_raw reaches ch_irq four cycles later, after two synchronizer stages, the pending register and the output register. The driver tasks record the exact due cycle of every expected value in a scoreboard. For latency-sensitive stimuli, they also record the old value one cycle earlier, so a result that arrives early or late fails.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_POL  = 7;
  localparam int unsigned BIT_MODE = 6;
  localparam int unsigned BIT_PEND = 5;
  localparam int unsigned BIT_EN   = 4;
  localparam int unsigned BIT_CLR  = 3;

  typedef struct packed {
    logic             pol;
    logic             edge_m;
    logic             en;
    logic [LVL_W-1:0] lvl;
  } chan_cfg_t;
endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
  parameter int unsigned W       = 8,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqb_channel.sv
module irqb_channel
  import irqb_pkg::*;
#(
  parameter logic REQ_IDLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_s,
  input  logic             wr_sel,
  input  chan_cfg_t        wr_cfg,
  input  logic             wr_clr,
  output logic [REG_W-1:0] rd_byte,
  output logic             active,
  output logic [LVL_W-1:0] act_lvl
);
  chan_cfg_t cfg_q;
  logic      pend_q;
  logic      prev_q;
  logic      rise, fall, hit, req_act, clr_cmd;

  assign rise    = req_s & ~prev_q;
  assign fall    = ~req_s & prev_q;
  assign hit     = cfg_q.pol ? rise : fall;
  assign req_act = cfg_q.pol ? req_s : ~req_s;
  assign clr_cmd = wr_sel & wr_clr & cfg_q.edge_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      prev_q <= REQ_IDLE;
    end else begin
      prev_q <= req_s;
      if (wr_sel) cfg_q <= wr_cfg;
      if (!cfg_q.edge_m)  pend_q <= req_act;
      else if (hit)       pend_q <= 1'b1;
      else if (clr_cmd)   pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_byte           = '0;
    rd_byte[BIT_POL]  = cfg_q.pol;
    rd_byte[BIT_MODE] = cfg_q.edge_m;
    rd_byte[BIT_PEND] = pend_q;
    rd_byte[BIT_EN]   = cfg_q.en;
    rd_byte[LVL_W-1:0] = cfg_q.lvl;
  end

  assign active  = pend_q & cfg_q.en & (|cfg_q.lvl);
  assign act_lvl = active ? cfg_q.lvl : '0;
endmodule

// File: rtl/irqb_maxlvl.sv
module irqb_maxlvl #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N*LW-1:0] lvls,
  output logic [LW-1:0]   max_q
);
  logic [LW-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < int'(N); i++)
      if (lvls[i*LW +: LW] > best) best = lvls[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) max_q <= '0;
    else     max_q <= best;
  end
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
  import irqb_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 'h10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        REQ_IDLE    = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  input  logic [NUM_CH-1:0]       irq_raw,
  output logic [NUM_CH-1:0]       ch_irq,
  output logic [NUM_CH*LVL_W-1:0] ch_lvl,
  output logic [LVL_W-1:0]        top_lvl
);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-1:0]       off;
  logic                    in_range;
  logic [IDX_W-1:0]        idx;
  logic [NUM_CH-1:0]       req_s;
  logic [NUM_CH-1:0]       act;
  logic [NUM_CH*LVL_W-1:0] act_lvl;
  logic [REG_W-1:0]        ch_rd [NUM_CH];
  chan_cfg_t               wr_cfg;
  logic                    bus_wdata_unused;

  assign off      = bus_addr - ADDR_W'(BASE_ADDR);
  assign in_range = (bus_addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(NUM_CH));
  assign idx      = off[IDX_W-1:0];

  assign wr_cfg.pol    = bus_wdata[BIT_POL];
  assign wr_cfg.edge_m = bus_wdata[BIT_MODE];
  assign wr_cfg.en     = bus_wdata[BIT_EN];
  assign wr_cfg.lvl    = bus_wdata[LVL_W-1:0];
  assign bus_wdata_unused = bus_wdata[BIT_PEND];

  irqb_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(REQ_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(irq_raw), .q(req_s)
  );

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
    irqb_channel #(.REQ_IDLE(REQ_IDLE)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .req_s   (req_s[i]),
      .wr_sel  (bus_wr && in_range && (idx == IDX_W'(i))),
      .wr_cfg  (wr_cfg),
      .wr_clr  (bus_wdata[BIT_CLR]),
      .rd_byte (ch_rd[i]),
      .active  (act[i]),
      .act_lvl (act_lvl[i*LVL_W +: LVL_W])
    );
  end

  irqb_maxlvl #(.N(NUM_CH), .LW(LVL_W)) u_max (
    .clk(clk), .rst(rst), .lvls(act_lvl), .max_q(top_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      ch_irq    <= '0;
      ch_lvl    <= '0;
    end else begin
      bus_rdata <= in_range ? ch_rd[idx] : '0;
      ch_irq    <= act;
      ch_lvl    <= act_lvl;
    end
  end
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned LW     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [7:0]           bus_rdata,
  input logic [NUM_CH-1:0]    ch_irq,
  input logic [NUM_CH*LW-1:0] ch_lvl,
  input logic [LW-1:0]        top_lvl
);
  a_r4_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[3] == 1'b0);

  a_r10_top_idle: assert property (@(posedge clk) disable iff (rst)
    (ch_irq == '0) |-> (top_lvl == '0));

  a_r11_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_irq == '0 && top_lvl == '0 && bus_rdata == '0));

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_a
    a_r9_level_nonzero: assert property (@(posedge clk) disable iff (rst)
      ch_irq[i] |-> (ch_lvl[i*LW +: LW] != '0));
    a_r9_level_quiet: assert property (@(posedge clk) disable iff (rst)
      !ch_irq[i] |-> (ch_lvl[i*LW +: LW] == '0));
    a_r10_top_bound: assert property (@(posedge clk) disable iff (rst)
      ch_irq[i] |-> (top_lvl >= ch_lvl[i*LW +: LW]));
  end
endmodule

bind irq_ctrl_bank irqb_checker #(.NUM_CH(NUM_CH), .LW(3)) u_chk (
  .clk(clk), .rst(rst), .bus_rdata(bus_rdata), .ch_irq(ch_irq),
  .ch_lvl(ch_lvl), .top_lvl(top_lvl)
);

// File: tb/tb_irq_ctrl_bank.sv
module tb_irq_ctrl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_IRQ = 1, K_TOP = 2, K_LVL = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_raw = 8'hFF;
  logic [7:0] ch_irq;
  logic [23:0] ch_lvl;
  logic [2:0] top_lvl;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int    due;
    int    kind;
    int    idx;
    int    val;
    string tag;
  } item_t;
  item_t sb[$];

  irq_ctrl_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_raw(irq_raw),
    .ch_irq(ch_irq), .ch_lvl(ch_lvl), .top_lvl(top_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every scoreboard item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        int act;
        case (sb[i].kind)
          K_RD:    act = int'(bus_rdata);
          K_IRQ:   act = int'(ch_irq);
          K_TOP:   act = int'(top_lvl);
          default: act = int'(ch_lvl[sb[i].idx*3 +: 3]);
        endcase
        checks++;
        if (sb[i].due < cyc || act != sb[i].val) begin
          errors++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h cycle=%0d",
                   sb[i].tag, sb[i].kind, act, sb[i].val, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic expect_at(int kind, int idx, int val, int dly, string tag);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.idx = idx; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, int val, string tag);
    step();
    bus_addr = a;
    expect_at(K_RD, 0, val, 1, tag);
  endtask

  task automatic set_raw(logic [7:0] v);
    step();
    irq_raw = v;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R11 reset state
    expect_at(K_IRQ, 0, 0, 1, "R11 ch_irq after reset");
    expect_at(K_TOP, 0, 0, 1, "R11 top_lvl after reset");
    for (int a = 'h10; a < 'h18; a++) rd(8'(a), 0, "R11 register reset value");

    // R2 R3 R4: write all ones, pending and clear bits read 0
    wr(8'h10, 8'hFF);
    rd(8'h10, 'hD7, "R2 R3 R4 readback of 0xFF write");

    // R1 out-of-range accesses
    wr(8'h18, 8'hFF);
    wr(8'h0F, 8'hFF);
    rd(8'h18, 0, "R1 read above window");
    rd(8'h0F, 0, "R1 read below window");
    rd(8'h17, 0, "R1 write outside window left ch7 untouched");
    rd(8'h11, 0, "R1 ch1 untouched by ch0 write");

    // R5 R8 edge mode, rising edge, level 5
    wr(8'h10, 8'hD5);
    set_raw(8'hFE);                       // falling edge: ignored with polarity 1
    expect_at(K_IRQ, 0, 0, 4, "R8 falling edge ignored when polarity 1");
    idle(5);
    set_raw(8'hFF);                       // rising edge
    expect_at(K_IRQ, 0, 'h00, 3, "R9 no interrupt before fourth edge");
    expect_at(K_IRQ, 0, 'h01, 4, "R5 edge sets interrupt");
    expect_at(K_LVL, 0, 5, 4, "R9 ch0 level");
    expect_at(K_TOP, 0, 5, 4, "R10 top level 5");
    idle(5);
    set_raw(8'hFE);                       // request removed
    idle(5);
    expect_at(K_IRQ, 0, 'h01, 1, "R5 latch holds after request removed");
    rd(8'h10, 'hF5, "R5 pending bit set");
    // R6 clear command in edge mode
    wr(8'h10, 8'hDD);
    expect_at(K_IRQ, 0, 'h00, 1, "R6 clear command drops interrupt");
    expect_at(K_TOP, 0, 0, 1, "R10 top level back to 0");
    rd(8'h10, 'hD5, "R6 pending cleared, R4 clear reads 0");
    set_raw(8'hFF);
    idle(6);
    wr(8'h10, 8'hDD);
    idle(2);

    // R7 R8 level mode, active low, channel 2 level 3
    wr(8'h12, 8'h13);
    idle(4);
    expect_at(K_IRQ, 0, 'h00, 1, "R8 idle-high request inactive with polarity 0");
    idle(1);
    set_raw(8'hFB);
    expect_at(K_IRQ, 0, 'h00, 3, "R7 level not yet through synchronizer");
    expect_at(K_IRQ, 0, 'h04, 4, "R7 low request active");
    expect_at(K_LVL, 2, 3, 4, "R9 ch2 level");
    idle(5);
    rd(8'h12, 'h33, "R7 pending reads 1");
    wr(8'h12, 8'h1B);
    expect_at(K_IRQ, 0, 'h04, 2, "R6 clear command ignored in level mode");
    rd(8'h12, 'h33, "R6 pending unchanged in level mode");
    set_raw(8'hFF);
    expect_at(K_IRQ, 0, 'h04, 3, "R7 release not yet visible");
    expect_at(K_IRQ, 0, 'h00, 4, "R7 released request drops interrupt");
    idle(5);

    // R9 level 0 never interrupts (channel 4, level mode, polarity 1)
    wr(8'h14, 8'h90);
    idle(4);
    expect_at(K_IRQ, 0, 'h00, 1, "R9 level 0 never interrupts");
    rd(8'h14, 'hB0, "R9 pending set at level 0");
    // R9 enable off
    wr(8'h14, 8'h83);
    expect_at(K_IRQ, 0, 'h00, 1, "R9 disabled channel silent");
    rd(8'h14, 'hA3, "R2 enable cleared readback");
    wr(8'h14, 8'h93);
    expect_at(K_IRQ, 0, 'h10, 1, "R9 enable raises interrupt");
    expect_at(K_TOP, 0, 3, 1, "R10 top level 3");

    // R10 priority across channels (channel 7 level 6 then 2)
    wr(8'h17, 8'h96);
    expect_at(K_IRQ, 0, 'h10, 1, "R9 level-mode write one cycle later");
    expect_at(K_IRQ, 0, 'h90, 2, "R9 ch7 joins");
    expect_at(K_TOP, 0, 6, 2, "R10 top picks level 6");
    idle(3);
    wr(8'h17, 8'h92);
    expect_at(K_TOP, 0, 3, 1, "R10 top picks level 3 over 2");
    expect_at(K_LVL, 7, 2, 1, "R9 ch7 level 2");
    expect_at(K_LVL, 4, 3, 1, "R9 ch4 level 3");
    idle(4);

    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard residue actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule